// File: doc/BRIEF.md
# Target-Side Byte Handshake Engine

This block moves single bytes across an 8-bit parallel peripheral bus that carries a parity line. It sits on the target end of the bus, and each transfer uses one REQ/ACK handshake. The local logic issues a one-cycle start pulse, chooses a direction and, for an outbound byte, supplies that byte. The engine then runs the whole handshake with the initiator and ends it with a one-cycle done pulse.

On an outbound transfer the engine first places the byte and its parity bit on the bus. It waits a fixed settling interval before it raises REQ. It holds the data steady until ACK arrives, then drops both REQ and its data drivers. On an inbound transfer it raises REQ at once and captures the byte when ACK arrives. It checks that byte for odd parity and then drops REQ.

In both directions the engine waits for the initiator to withdraw ACK before it reports done. It accepts no new start until it reports done. All bus pins are active-low. The data lines are modelled as a driven value, an output enable and a sampled value.

Top module: `bus_xfer_engine`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `req_n_o` is 1 and `db_oe_o`, `done`, `busy` and `parity_err` are all 0.
- R2: For a start with `dir_send`=1, `db_oe_o` is 1 from the next clock edge on. `req_n_o` goes to 0 exactly `SKEW_CYC` edges after the drivers turn on (default 4).
- R3: While the engine drives the bus, `db_n_o` does not change. This holds during the settling interval and while REQ waits for ACK, even if the local `tx_byte` input changes.
- R4: On an outbound transfer, the first edge that samples `ack_n_i`=0 while `req_n_o`=0 sets `req_n_o` to 1 and `db_oe_o` to 0.
- R5: Once REQ is released, `done` pulses high for exactly one cycle. The pulse comes on the edge after `ack_n_i` is sampled back at 1, and `busy` falls on that same edge. Until then `busy` stays 1 and `done` stays 0.
- R6: For a start with `dir_send`=0, `req_n_o` goes to 0 on the next edge and `db_oe_o` stays 0.
- R7: On an inbound transfer, the edge that first samples `ack_n_i`=0 captures `~db_n_i[7:0]` into `rx_byte` and sets `req_n_o` to 1. `rx_byte` keeps that value after the initiator releases the bus.
- R8: The parity line is bit 8 of the data bus. When the engine drives the bus, the nine asserted bits `~db_n_o` contain an odd number of ones.
- R9: If a received byte's nine asserted bits hold an even number of ones, `parity_err` goes to 1 and the byte is still delivered. The flag stays 1 through later transfers and only `rst_n` clears it.
- R10: A `bus_rst` sampled high returns `req_n_o` to 1 and `db_oe_o` and `busy` to 0 on that edge, and the aborted transfer gives no `done`.
- R11: A start pulse while `busy` is 1 has no effect on direction, driven byte or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Bus reset, aborts any transfer |
| start | input | 1 | One-cycle request to begin a transfer |
| dir_send | input | 1 | 1: target sends, 0: target receives |
| tx_byte | input | DATA_W | Byte to send, captured at start |
| done | output | 1 | One-cycle pulse at transfer completion |
| busy | output | 1 | Transfer in progress |
| rx_byte | output | DATA_W | Last received byte |
| parity_err | output | 1 | Sticky received-parity error |
| req_n_o | output | 1 | REQ line, active low |
| ack_n_i | input | 1 | ACK line, active low |
| db_oe_o | output | 1 | Data/parity driver enable |
| db_n_o | output | DATA_W+1 | Driven data and parity (bit 8), active low |
| db_n_i | input | DATA_W+1 | Sampled data and parity (bit 8), active low |

## Verification
Every result follows a fixed number of edges after its stimulus. Drivers turn on one edge after start, and REQ follows `SKEW_CYC` edges after that. REQ is released one edge after ACK is sampled, and done follows one edge after ACK is withdrawn. A bus reset takes effect on the edge that samples it. The bench changes inputs and reads outputs only on falling edges and counts falling edges between events, so each check lands on the exact cycle the requirement names. A queue pairs every started transfer with its expected byte and error flag, and a monitor compares each one when done pulses. Aborted transfers push nothing, so a spurious done shows up as a mismatch against an empty queue.

// File: rtl/bxe_pkg.sv
// Package for the byte handshake engine: handshake state encoding.
package bxe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,   // no transfer
        ST_SETUP    = 3'd1,   // outbound data driven, settling
        ST_SEND_REQ = 3'd2,   // outbound REQ asserted, waiting for ACK
        ST_RECV_REQ = 3'd3,   // inbound REQ asserted, waiting for ACK
        ST_RELEASE  = 3'd4    // REQ dropped, waiting for ACK release
    } bxe_state_e;

endpackage

// File: rtl/bxe_odd_parity.sv
// Odd parity helper.
// Generates the parity bit that makes data plus parity hold an odd count of
// ones, and flags a received data/parity pair whose count is even.
// Assumes: inputs are in asserted (true-high) polarity.
module bxe_odd_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic         par_in,
    output logic         par_gen,
    output logic         par_bad
);

    // Generate bit and check result from one reduction each.
    always_comb begin
        par_gen = ~(^data);
        par_bad = ~(^{par_in, data});
    end

endmodule

// File: rtl/bxe_skew_timer.sv
// Settling-interval down counter.
// Loaded when outbound data starts driving; expired is high once the
// programmed interval has elapsed. Assumes SKEW_CYC >= 1.
module bxe_skew_timer #(
    parameter int SKEW_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = $clog2(SKEW_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Reload on start of drive, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(SKEW_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Interval complete when the count reaches zero.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/bxe_hs_fsm.sv
// Handshake sequencer for one byte per REQ/ACK cycle.
// Steps idle -> (settle -> REQ) or (REQ) -> release -> idle, emits a capture
// strobe for inbound bytes and a registered done pulse.
// Assumes ack_act is already synchronous to clk; bus_rst has top priority.
module bxe_hs_fsm
    import bxe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       start,
    input  logic       send,
    input  logic       ack_act,
    input  logic       skew_done,
    output bxe_state_e state_o,
    output logic       load_timer,
    output logic       latch_rx,
    output logic       done_o
);

    bxe_state_e state_q, state_d;
    logic       done_q;

    // Next-state and strobe decode.
    always_comb begin
        state_d    = state_q;
        load_timer = 1'b0;
        latch_rx   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (send) begin
                        state_d    = ST_SETUP;
                        load_timer = 1'b1;
                    end else begin
                        state_d = ST_RECV_REQ;
                    end
                end
            end
            ST_SETUP:    if (skew_done) state_d = ST_SEND_REQ;
            ST_SEND_REQ: if (ack_act) state_d = ST_RELEASE;
            ST_RECV_REQ: begin
                if (ack_act) begin
                    state_d  = ST_RELEASE;
                    latch_rx = 1'b1;
                end
            end
            ST_RELEASE:  if (!ack_act) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (bus_rst) begin
            state_d    = ST_IDLE;
            load_timer = 1'b0;
            latch_rx   = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Done pulse when ACK is withdrawn after release, never on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_RELEASE) && !ack_act && !bus_rst;
    end

    assign state_o = state_q;
    assign done_o  = done_q;

endmodule

// File: rtl/bus_xfer_engine.sv
// Target-side byte handshake engine, top level.
// Captures the outbound byte at start, drives data plus odd parity, raises
// REQ after SKEW_CYC cycles, captures inbound bytes on ACK and keeps a sticky
// parity error. Assumes bus inputs are already synchronised to clk.
module bus_xfer_engine
    import bxe_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SKEW_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              start,
    input  logic              dir_send,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              done,
    output logic              busy,
    output logic [DATA_W-1:0] rx_byte,
    output logic              parity_err,
    output logic              req_n_o,
    input  logic              ack_n_i,
    output logic              db_oe_o,
    output logic [DATA_W:0]   db_n_o,
    input  logic [DATA_W:0]   db_n_i
);

    localparam int BUS_W = DATA_W + 1;

    bxe_state_e        state;
    logic              load_timer, latch_rx, skew_done;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic              perr_q;
    logic              tx_par, rx_par_unused, rx_bad, tx_chk_unused;
    logic [BUS_W-1:0]  bus_in_act;

    always_comb bus_in_act = ~db_n_i;

    bxe_hs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (bus_rst),
        .start      (start),
        .send       (dir_send),
        .ack_act    (~ack_n_i),
        .skew_done  (skew_done),
        .state_o    (state),
        .load_timer (load_timer),
        .latch_rx   (latch_rx),
        .done_o     (done)
    );

    bxe_skew_timer #(.SKEW_CYC(SKEW_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_timer),
        .expired (skew_done)
    );

    bxe_odd_parity #(.W(DATA_W)) u_tx_par (
        .data    (tx_q),
        .par_in  (1'b0),
        .par_gen (tx_par),
        .par_bad (tx_chk_unused)
    );

    bxe_odd_parity #(.W(DATA_W)) u_rx_par (
        .data    (bus_in_act[DATA_W-1:0]),
        .par_in  (bus_in_act[DATA_W]),
        .par_gen (rx_par_unused),
        .par_bad (rx_bad)
    );

    // Hold the outbound byte for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       tx_q <= '0;
        else if (state == ST_IDLE && start && dir_send)   tx_q <= tx_byte;
    end

    // Capture inbound byte on the ACK strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (latch_rx) rx_q <= bus_in_act[DATA_W-1:0];
    end

    // Sticky parity error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 perr_q <= 1'b0;
        else if (latch_rx && rx_bad) perr_q <= 1'b1;
    end

    // Bus pin decode from the registered state.
    always_comb begin
        req_n_o = !(state == ST_SEND_REQ || state == ST_RECV_REQ);
        db_oe_o = (state == ST_SETUP || state == ST_SEND_REQ);
        db_n_o  = ~{tx_par, tx_q};
        busy    = (state != ST_IDLE);
    end

    assign rx_byte    = rx_q;
    assign parity_err = perr_q;

endmodule

// File: rtl/bxe_engine_chk.sv
// Property checker for bus_xfer_engine, attached by bind.
// Watches only ports; counts driven cycles to time the REQ delay.
module bxe_engine_chk #(
    parameter int DATA_W   = 8,
    parameter int SKEW_CYC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rst,
    input logic            done,
    input logic            busy,
    input logic            parity_err,
    input logic            req_n_o,
    input logic            ack_n_i,
    input logic            db_oe_o,
    input logic [DATA_W:0] db_n_o
);

    localparam int CW = $clog2(SKEW_CYC + 2) + 1;

    logic [CW-1:0] drv_cnt;

    // Count cycles that data has been driven ahead of REQ.
    always_ff @(posedge clk) begin
        if (!rst_n || !db_oe_o) drv_cnt <= '0;
        else if (req_n_o)       drv_cnt <= drv_cnt + 1'b1;
    end

    // R2
    req_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe_o && $fell(req_n_o)) |-> (drv_cnt == CW'(SKEW_CYC)));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe_o && $past(db_oe_o)) |-> $stable(db_n_o));

    // R4
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n_o && !ack_n_i) |=> (req_n_o && !db_oe_o));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_n_o |-> busy);

    // R8
    odd_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe_o |-> ($countones(~db_n_o) % 2 == 1));

    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |=> parity_err);

    // R10
    bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (req_n_o && !db_oe_o && !busy));

endmodule

bind bus_xfer_engine bxe_engine_chk #(
    .DATA_W   (DATA_W),
    .SKEW_CYC (SKEW_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst    (bus_rst),
    .done       (done),
    .busy       (busy),
    .parity_err (parity_err),
    .req_n_o    (req_n_o),
    .ack_n_i    (ack_n_i),
    .db_oe_o    (db_oe_o),
    .db_n_o     (db_n_o)
);

// File: tb/test_bus_xfer_engine.sv
module test_bus_xfer_engine;

    localparam int CLK_PERIOD = 10;
    localparam int SKEW       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       start = 1'b0;
    logic       dir_send = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       done, busy, parity_err, req_n_o, db_oe_o;
    logic [7:0] rx_byte;
    logic       ack_n_i = 1'b1;
    logic [8:0] db_n_o;
    logic [8:0] db_n_i = 9'h1FF;

    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;
    logic [9:0] exp_q[$];     // {dir_send, exp_err, byte}
    logic [7:0] seen_byte = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_xfer_engine #(.DATA_W(8), .SKEW_CYC(SKEW)) i_bus_xfer_engine (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .start(start),
        .dir_send(dir_send), .tx_byte(tx_byte), .done(done), .busy(busy),
        .rx_byte(rx_byte), .parity_err(parity_err), .req_n_o(req_n_o),
        .ack_n_i(ack_n_i), .db_oe_o(db_oe_o), .db_n_o(db_n_o), .db_n_i(db_n_i)
    );

    function automatic logic opar(input logic [7:0] b);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(b[i]);
        return (ones % 2 == 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: one expected item per done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected done", 32'd1, 32'd0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                if (e[9]) chk(seen_byte == e[7:0], "R3 sent byte", {24'd0, seen_byte}, {24'd0, e[7:0]});
                else begin
                    chk(rx_byte == e[7:0], "R7 received byte", {24'd0, rx_byte}, {24'd0, e[7:0]});
                    chk(parity_err == e[8], "R9 parity flag", {31'd0, parity_err}, {31'd0, e[8]});
                end
            end
        end
    end

    task automatic do_send(input logic [7:0] b, input int hold, input bit poke);
        logic [8:0] drv;
        int k;
        exp_q.push_back({1'b1, 1'b0, b});
        @(negedge clk); start = 1'b1; dir_send = 1'b1; tx_byte = b;
        @(negedge clk); start = 1'b0; tx_byte = 8'h00;
        chk(db_oe_o && req_n_o, "R2 drive before REQ", {30'd0, db_oe_o, req_n_o}, 32'd3);
        chk(db_n_o == ~{opar(b), b}, "R8 odd parity on bus", {23'd0, db_n_o}, {23'd0, ~{opar(b), b}});
        drv = db_n_o;
        k = 0;
        if (poke) begin   // R11: start while busy must be ignored
            start = 1'b1; dir_send = 1'b0; tx_byte = 8'h5A;
            @(negedge clk); start = 1'b0; k = 1;
            chk(db_oe_o && db_n_o == drv, "R11 start ignored", {23'd0, db_n_o}, {23'd0, drv});
        end
        while (req_n_o && k <= SKEW + 2) begin
            @(negedge clk); k++;
            chk(db_n_o == drv, "R3 stable in settle", {23'd0, db_n_o}, {23'd0, drv});
        end
        chk(k == SKEW, "R2 REQ delay", k, SKEW);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(!req_n_o && db_n_o == drv, "R3 stable with REQ", {23'd0, db_n_o}, {23'd0, drv});
        end
        seen_byte = ~db_n_o[7:0];
        ack_n_i = 1'b0;
        @(negedge clk);
        chk(req_n_o && !db_oe_o, "R4 release on ACK", {30'd0, req_n_o, db_oe_o}, 32'd2);
        chk(busy && !done, "R5 wait ACK release", {30'd0, busy, done}, 32'd2);
        ack_n_i = 1'b1;
        @(negedge clk);
        chk(done && !busy, "R5 done pulse", {30'd0, done, busy}, 32'd2);
        @(negedge clk);
        chk(!done, "R5 single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic do_recv(input logic [7:0] b, input logic par, input logic exp_err);
        exp_q.push_back({1'b0, exp_err, b});
        @(negedge clk); start = 1'b1; dir_send = 1'b0;
        @(negedge clk); start = 1'b0;
        chk(!req_n_o && !db_oe_o, "R6 REQ on receive", {30'd0, req_n_o, db_oe_o}, 32'd0);
        db_n_i = ~{par, b};
        @(negedge clk); ack_n_i = 1'b0;
        @(negedge clk);
        chk(req_n_o, "R7 REQ drop after capture", {31'd0, req_n_o}, 32'd1);
        db_n_i = 9'h1FF; ack_n_i = 1'b1;
        @(negedge clk);
        chk(done, "R5 done after receive", {31'd0, done}, 32'd1);
        chk(rx_byte == b, "R7 byte held after release", {24'd0, rx_byte}, {24'd0, b});
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!done, "R10 no done after abort", {31'd0, done}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_n_o && !db_oe_o && !done && !busy && !parity_err, "R1 in reset",
            {27'd0, req_n_o, db_oe_o, done, busy, parity_err}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_n_o && !db_oe_o && !done && !busy && !parity_err, "R1 after reset",
            {27'd0, req_n_o, db_oe_o, done, busy, parity_err}, 32'h10);

        do_send(8'hA5, 0, 1'b0);
        do_send(8'h00, 3, 1'b1);
        do_send(8'hFF, 1, 1'b0);

        do_recv(8'h3C, opar(8'h3C), 1'b0);
        do_recv(8'h81, ~opar(8'h81), 1'b1);
        do_recv(8'h7E, opar(8'h7E), 1'b1);

        // R10: abort during settle interval
        @(negedge clk); start = 1'b1; dir_send = 1'b1; tx_byte = 8'hC3;
        @(negedge clk); start = 1'b0;
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        chk(req_n_o && !db_oe_o && !busy, "R10 abort send", {29'd0, req_n_o, db_oe_o, busy}, 32'd4);
        quiet(6);

        // R10: abort while receive REQ is asserted
        @(negedge clk); start = 1'b1; dir_send = 1'b0;
        @(negedge clk); start = 1'b0; bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        chk(req_n_o && !busy, "R10 abort receive", {30'd0, req_n_o, busy}, 32'd2);
        quiet(4);

        // R9: only reset clears the sticky flag
        chk(parity_err, "R9 flag kept", {31'd0, parity_err}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!parity_err, "R9 cleared by reset", {31'd0, parity_err}, 32'd0);

        do_send(8'h6D, 2, 1'b0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all transfers done", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule